// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one memory-to-memory DMA channel. A host sets up a 24-bit source address, a 24-bit destination address and a byte count through four 32-bit registers, then sets a go bit in the control register. The channel then moves the data one operand at a time. For each operand it requests a shared bus and waits for a grant. It runs a read cycle at the source address and then a write cycle at the destination address. Each cycle holds until the addressed slave acknowledges it. It then returns to idle and decides whether to start the next operand.

An operand is a single byte or a 16-bit word. Word moves need word mode and an even address in both pointers. Each pointer can be set to advance after every operand or to stay fixed, which suits a peripheral data register. Pointer arithmetic wraps inside the 24-bit space.

Transfers start either on the channel's own initiative or only while an external request line is high. Clearing the go bit stops the channel cleanly at the next operand boundary, and setting it again resumes the transfer. A reset bit in the control register aborts the channel at once. When the count reaches zero, the channel clears go, sets a done flag and pulses its interrupt output for one clock.

Top module: `dma_chan`

## Requirements
- R1: After `rst_n` is held low, all four registers read zero and `bus_req`, `bus_cyc` and `irq` are low. Register index 0 is control, 1 is source, 2 is destination and 3 is count.
- R2: The source and destination registers store 24 bits. Bits 31:24 always read back as zero.
- R3: The read cycle puts the source pointer on `bus_addr` with `bus_wr` low. The write cycle puts the destination pointer there with `bus_wr` high. The write carries the data just read: `bus_wdata[7:0]` for a byte, all 16 bits for a word.
- R4: Control bit 2 lets the source pointer advance after each operand, and control bit 3 does the same for the destination pointer. When the bit is 0, that pointer stays unchanged.
- R5: An operand is a word (`bus_size` high) when control bit 4 is set, both pointers are even and the count is at least 2. Otherwise it is a byte. An advancing pointer steps by the operand size, 2 or 1.
- R6: Pointer arithmetic is unsigned and wraps from 0xFFFFFF to 0x000000. For example, a word at 0xFFFFFE leaves the pointer at 0x000000.
- R7: The count drops by the operand size after each write. When it reaches zero, go (control bit 0) clears, done (control bit 8) sets and `irq` is high for exactly one clock. Any host write to the control register clears done.
- R8: In internal mode (control bit 5 = 0), `bus_req` rises exactly one clock after the register write that sets go. A bus cycle starts only after `bus_gnt` is seen.
- R9: In external mode (control bit 5 = 1), `ext_dreq` has no effect while go is 0. With go set, an operand begins only while `ext_dreq` is high.
- R10: Clearing go lets the current operand finish and then holds the channel idle, with pointers and count kept. Setting go again resumes the transfer and completes it correctly.
- R11: Writing control bit 1 as 1 drops `bus_cyc` and `bus_req` on the next clock and clears every control and status bit. The reset bit always reads back 0, and the pointers and count keep their values.
- R12: Each bus cycle keeps `bus_cyc`, `bus_wr` and `bus_addr` steady until `bus_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | Host register access strobe |
| host_we | input | 1 | Host write enable (with host_sel) |
| host_addr | input | 2 | Register index |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Register read data for host_addr |
| bus_req | output | 1 | Bus request, held for a whole operand |
| bus_gnt | input | 1 | Bus grant |
| bus_cyc | output | 1 | Bus cycle active |
| bus_wr | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_size | output | 1 | 1 = 16-bit operand, 0 = byte |
| bus_addr | output | 24 | Bus byte address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data |
| bus_ack | input | 1 | Cycle acknowledge from the slave |
| ext_dreq | input | 1 | External transfer request (synchronous) |
| irq | output | 1 | One-clock completion pulse |

## Verification
A wrong pointer, step or count shows up in two places: the destination memory differs from a model copy, and the register read-back differs after the transfer ends. Both are checked as soon as done rises. A sequencer that is in the wrong state shows on the bus wires within a clock. Examples are a request a clock early or late after go, a cycle that moves on without acknowledge, a request taken while stopped, and a cycle that survives the reset bit. Each of these is compared on the cycle it should happen. A stop that loses state shows as a wrong count or pointer while the channel is parked, before the resume.

// File: rtl/dma_chan_pkg.sv
// Package: shared register indices, control bit positions, sequencer
// state type and control struct for the DMA channel.
package dma_chan_pkg;

    localparam int unsigned HOST_W = 32;
    localparam int unsigned BUS_DW = 16;

    localparam logic [1:0] IDX_CTRL = 2'd0;
    localparam logic [1:0] IDX_SRC  = 2'd1;
    localparam logic [1:0] IDX_DST  = 2'd2;
    localparam logic [1:0] IDX_CNT  = 2'd3;

    localparam int unsigned BIT_GO      = 0;
    localparam int unsigned BIT_CLR     = 1;
    localparam int unsigned BIT_SRC_INC = 2;
    localparam int unsigned BIT_DST_INC = 3;
    localparam int unsigned BIT_WIDE    = 4;
    localparam int unsigned BIT_EXT     = 5;
    localparam int unsigned BIT_DONE    = 8;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_REQ  = 2'd1,
        SEQ_RD   = 2'd2,
        SEQ_WR   = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic ext_mode;
        logic wide;
        logic dst_inc;
        logic src_inc;
        logic go;
    } chan_ctrl_t;

endpackage

// File: rtl/dma_ptr_unit.sv
// Module: one address pointer. It advances by 1 or 2 after an operand when
// enabled, or loads from the host. Assumes the sequencer and the host never
// need the same edge (the advance wins). The sum wraps at ADDR_W bits.
module dma_ptr_unit #(
    parameter int unsigned ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              adv,
    input  logic              inc_en,
    input  logic              wide_step,
    output logic [ADDR_W-1:0] ptr
);

    logic [ADDR_W-1:0] step;

    // Step size from the operand width of the finishing operand.
    always_comb step = wide_step ? ADDR_W'(2) : ADDR_W'(1);

    // Pointer register: advance, else host load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (adv && inc_en) begin
            ptr <= ptr + step;
        end else if (load) begin
            ptr <= load_val;
        end
    end

endmodule

// File: rtl/dma_regs.sv
// Module: host-visible control and status, byte count and read mux.
// Assumes single-cycle host writes and combinational reads. The reset bit
// is not stored: it acts as a one-cycle abort and reads back 0.
module dma_regs
    import dma_chan_pkg::*;
#(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_we,
    input  logic [1:0]        host_addr,
    input  logic [HOST_W-1:0] host_wdata,
    output logic [HOST_W-1:0] host_rdata,
    input  logic [ADDR_W-1:0] src_ptr,
    input  logic [ADDR_W-1:0] dst_ptr,
    input  logic              op_done,
    input  logic              op_wide,
    output chan_ctrl_t        ctrl,
    output logic              done,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              abort,
    output logic              src_load,
    output logic              dst_load,
    output logic              irq
);

    logic             wr_en;
    logic             ctrl_wr;
    logic             cnt_wr;
    logic [CNT_W-1:0] step;
    logic             finishing;
    logic             unused_wdata_hi;

    // Decode host writes per register.
    always_comb begin
        wr_en    = host_sel && host_we;
        ctrl_wr  = wr_en && (host_addr == IDX_CTRL);
        cnt_wr   = wr_en && (host_addr == IDX_CNT);
        src_load = wr_en && (host_addr == IDX_SRC);
        dst_load = wr_en && (host_addr == IDX_DST);
        abort    = ctrl_wr && host_wdata[BIT_CLR];
    end

    // Count step and last-operand detection.
    always_comb begin
        step      = op_wide ? CNT_W'(2) : CNT_W'(1);
        finishing = op_done && (cnt_q == step);
    end

    assign unused_wdata_hi = ^host_wdata[HOST_W-1:ADDR_W];

    // Control and done flag: abort clears, host writes, completion wins last.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            ctrl <= '0;
            done <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                ctrl.go       <= host_wdata[BIT_GO];
                ctrl.src_inc  <= host_wdata[BIT_SRC_INC];
                ctrl.dst_inc  <= host_wdata[BIT_DST_INC];
                ctrl.wide     <= host_wdata[BIT_WIDE];
                ctrl.ext_mode <= host_wdata[BIT_EXT];
                done          <= 1'b0;
            end
            if (finishing) begin
                ctrl.go <= 1'b0;
                done    <= 1'b1;
            end
        end
    end

    // Byte count: decrement per operand, else host load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (op_done) begin
            cnt_q <= cnt_q - step;
        end else if (cnt_wr) begin
            cnt_q <= host_wdata[CNT_W-1:0];
        end
    end

    // Completion pulse, one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= finishing && !abort;
    end

    // Host read mux; unused bits read zero.
    always_comb begin
        host_rdata = '0;
        unique case (host_addr)
            IDX_CTRL: begin
                host_rdata[BIT_GO]      = ctrl.go;
                host_rdata[BIT_SRC_INC] = ctrl.src_inc;
                host_rdata[BIT_DST_INC] = ctrl.dst_inc;
                host_rdata[BIT_WIDE]    = ctrl.wide;
                host_rdata[BIT_EXT]     = ctrl.ext_mode;
                host_rdata[BIT_DONE]    = done;
            end
            IDX_SRC: host_rdata[ADDR_W-1:0] = src_ptr;
            IDX_DST: host_rdata[ADDR_W-1:0] = dst_ptr;
            default: host_rdata[CNT_W-1:0]  = cnt_q;
        endcase
    end

endmodule

// File: rtl/dma_seq.sv
// Module: per-operand sequencer. The steps are idle, bus request, read
// cycle, then write cycle, and it returns to idle after each operand.
// Assumes ext_dreq and bus_ack are synchronous to clk. Abort forces idle.
module dma_seq
    import dma_chan_pkg::*;
#(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              go,
    input  logic              ext_mode,
    input  logic              wide_mode,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic [ADDR_W-1:0] src_ptr,
    input  logic [ADDR_W-1:0] dst_ptr,
    input  logic              ext_dreq,
    input  logic              bus_gnt,
    input  logic              bus_ack,
    input  logic [BUS_DW-1:0] bus_rdata,
    output logic              bus_req,
    output logic              bus_cyc,
    output logic              bus_wr,
    output logic              bus_size,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [BUS_DW-1:0] bus_wdata,
    output logic              op_done,
    output logic              op_wide
);

    seq_state_e        state;
    logic              wide_ok;
    logic              launch;
    logic [BUS_DW-1:0] data_q;

    // Operand size choice and start condition for the next operand.
    always_comb begin
        wide_ok = wide_mode && !src_ptr[0] && !dst_ptr[0] && (cnt_q > CNT_W'(1));
        launch  = go && (cnt_q != '0) && (!ext_mode || ext_dreq);
    end

    // State transitions, operand size latch and read data capture.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            state   <= SEQ_IDLE;
            op_wide <= 1'b0;
            data_q  <= '0;
        end else begin
            unique case (state)
                SEQ_IDLE: if (launch) begin
                    state   <= SEQ_REQ;
                    op_wide <= wide_ok;
                end
                SEQ_REQ: if (bus_gnt) state <= SEQ_RD;
                SEQ_RD: if (bus_ack) begin
                    state  <= SEQ_WR;
                    data_q <= op_wide ? bus_rdata : {8'h00, bus_rdata[7:0]};
                end
                default: if (bus_ack) state <= SEQ_IDLE;
            endcase
        end
    end

    // Bus outputs decoded from state.
    always_comb begin
        bus_req   = (state != SEQ_IDLE);
        bus_cyc   = (state == SEQ_RD) || (state == SEQ_WR);
        bus_wr    = (state == SEQ_WR);
        bus_size  = op_wide;
        bus_addr  = (state == SEQ_WR) ? dst_ptr : src_ptr;
        bus_wdata = data_q;
        op_done   = (state == SEQ_WR) && bus_ack && !abort;
    end

endmodule

// File: rtl/dma_chan.sv
// Module: top of the single-channel DMA engine. It joins the register
// block, the two pointer units (built by a generate loop) and the sequencer.
// Assumes one bus master per grant and a synchronous slave acknowledge.
module dma_chan
    import dma_chan_pkg::*;
#(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_we,
    input  logic [1:0]        host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_cyc,
    output logic              bus_wr,
    output logic              bus_size,
    output logic [23:0]       bus_addr,
    output logic [15:0]       bus_wdata,
    input  logic [15:0]       bus_rdata,
    input  logic              bus_ack,
    input  logic              ext_dreq,
    output logic              irq
);

    localparam int unsigned N_PTR = 2;

    chan_ctrl_t        ctrl_q;
    logic              done_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              abort;
    logic              op_done;
    logic              op_wide;
    logic              src_load;
    logic              dst_load;
    logic [ADDR_W-1:0] ptr_q    [N_PTR];
    logic              ptr_load [N_PTR];
    logic              ptr_inc  [N_PTR];
    logic [ADDR_W-1:0] src_ptr;
    logic [ADDR_W-1:0] dst_ptr;
    logic              chan_go;
    logic              chan_ext;
    logic              src_inc;

    // Per-pointer controls and named views for the checker.
    always_comb begin
        ptr_load[0] = src_load;
        ptr_load[1] = dst_load;
        ptr_inc[0]  = ctrl_q.src_inc;
        ptr_inc[1]  = ctrl_q.dst_inc;
        src_ptr     = ptr_q[0];
        dst_ptr     = ptr_q[1];
        chan_go     = ctrl_q.go;
        chan_ext    = ctrl_q.ext_mode;
        src_inc     = ctrl_q.src_inc;
    end

    dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_sel   (host_sel),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .src_ptr    (src_ptr),
        .dst_ptr    (dst_ptr),
        .op_done    (op_done),
        .op_wide    (op_wide),
        .ctrl       (ctrl_q),
        .done       (done_q),
        .cnt_q      (cnt_q),
        .abort      (abort),
        .src_load   (src_load),
        .dst_load   (dst_load),
        .irq        (irq)
    );

    for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
        dma_ptr_unit #(.ADDR_W(ADDR_W)) u_ptr (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (ptr_load[g]),
            .load_val  (host_wdata[ADDR_W-1:0]),
            .adv       (op_done),
            .inc_en    (ptr_inc[g]),
            .wide_step (op_wide),
            .ptr       (ptr_q[g])
        );
    end

    dma_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (abort),
        .go        (ctrl_q.go),
        .ext_mode  (ctrl_q.ext_mode),
        .wide_mode (ctrl_q.wide),
        .cnt_q     (cnt_q),
        .src_ptr   (src_ptr),
        .dst_ptr   (dst_ptr),
        .ext_dreq  (ext_dreq),
        .bus_gnt   (bus_gnt),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata),
        .bus_req   (bus_req),
        .bus_cyc   (bus_cyc),
        .bus_wr    (bus_wr),
        .bus_size  (bus_size),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .op_done   (op_done),
        .op_wide   (op_wide)
    );

endmodule

// File: rtl/dma_chan_checker.sv
// Module: protocol checker for dma_chan, attached by bind. It observes the
// ports and a few internal nets and drives nothing.
module dma_chan_checker #(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_sel,
    input logic              host_we,
    input logic [1:0]        host_addr,
    input logic [31:0]       host_wdata,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              bus_cyc,
    input logic              bus_wr,
    input logic [23:0]       bus_addr,
    input logic              bus_ack,
    input logic              irq,
    input logic              chan_go,
    input logic              chan_ext,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [ADDR_W-1:0] src_ptr,
    input logic              src_inc,
    input logic              op_done
);

    logic              host_wr;
    logic              clr_now;
    logic [ADDR_W-1:0] src_prev;
    logic [ADDR_W-1:0] src_delta;
    logic              unused_wdata;

    // Host write decode seen by the checker.
    always_comb begin
        host_wr   = host_sel && host_we;
        clr_now   = host_wr && (host_addr == 2'd0) && host_wdata[1];
        src_delta = src_ptr - src_prev;
    end

    assign unused_wdata = ^{host_wdata[31:2], host_wdata[0]};

    // Previous source pointer, for step measurement.
    always_ff @(posedge clk) begin
        if (!rst_n) src_prev <= '0;
        else        src_prev <= src_ptr;
    end

    AST_REQ_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chan_go) && !chan_ext && (cnt_q != '0) && !bus_req && !host_wr |=> bus_req); // R8
    AST_CYC_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cyc) |-> $past(bus_gnt)); // R8
    AST_NO_REQ_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(chan_go)); // R9
    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc && !bus_ack && !host_wr |=> bus_cyc && $stable(bus_addr) && $stable(bus_wr)); // R12
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R7
    AST_CNT_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        op_done && !host_wr |=> cnt_q < $past(cnt_q)); // R7
    AST_ABORT_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_now |=> !bus_req && !bus_cyc && !chan_go); // R11
    AST_SRC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        op_done && src_inc && !host_wr |=> (src_delta == ADDR_W'(1)) || (src_delta == ADDR_W'(2))); // R5

endmodule

bind dma_chan dma_chan_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_sel   (host_sel),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .bus_req    (bus_req),
    .bus_gnt    (bus_gnt),
    .bus_cyc    (bus_cyc),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_ack    (bus_ack),
    .irq        (irq),
    .chan_go    (chan_go),
    .chan_ext   (chan_ext),
    .cnt_q      (cnt_q),
    .src_ptr    (src_ptr),
    .src_inc    (src_inc),
    .op_done    (op_done)
);

// File: tb/dma_chan_bench.sv
module dma_chan_bench;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [23:0] src;
        logic [23:0] dst;
        logic [15:0] cnt;
        logic        wide;
        logic        src_inc;
        logic        dst_inc;
        logic [23:0] exp_src;
        logic [23:0] exp_dst;
    } vec_t;

    localparam int N_VEC = 8;
    localparam vec_t VECS [N_VEC] = '{
        '{24'h000010, 24'h000040, 16'd4, 1'b0, 1'b1, 1'b1, 24'h000014, 24'h000044}, // R5 bytes
        '{24'h000020, 24'h000060, 16'd6, 1'b1, 1'b1, 1'b1, 24'h000026, 24'h000066}, // R5 words
        '{24'h000021, 24'h000060, 16'd3, 1'b1, 1'b1, 1'b1, 24'h000024, 24'h000063}, // R5 odd fallback
        '{24'h000030, 24'h000070, 16'd4, 1'b1, 1'b0, 1'b1, 24'h000030, 24'h000074}, // R4 fixed source
        '{24'hFFFFFE, 24'h000080, 16'd4, 1'b1, 1'b1, 1'b1, 24'h000002, 24'h000084}, // R6 source wrap
        '{24'h000050, 24'hFFFFFF, 16'd2, 1'b0, 1'b1, 1'b1, 24'h000052, 24'h000001}, // R6 dest wrap
        '{24'h000090, 24'h0000A0, 16'd3, 1'b1, 1'b1, 1'b1, 24'h000093, 24'h0000A3}, // R5 tail byte
        '{24'h0000B0, 24'h0000C0, 16'd3, 1'b0, 1'b1, 1'b0, 24'h0000B3, 24'h0000C0}  // R4 fixed dest
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        bus_req;
    logic        bus_gnt = 1'b0;
    logic        bus_cyc;
    logic        bus_wr;
    logic        bus_size;
    logic [23:0] bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata = '0;
    logic        bus_ack = 1'b0;
    logic        ext_dreq = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int ack_lat = 0;
    int rd_seen = 0;
    logic [23:0] first_rd_addr = '0;
    logic [7:0]  mem     [256];
    logic [7:0]  exp_mem [256];

    dma_chan u_dma_chan (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cyc(bus_cyc), .bus_wr(bus_wr),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .ext_dreq(ext_dreq), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [7:0] pat(input logic [7:0] a);
        return a * 8'd7 + 8'd3;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Called just after a negedge: the write lands on the next posedge.
    task automatic host_write(input logic [1:0] idx, input logic [31:0] val);
        host_sel = 1'b1; host_we = 1'b1; host_addr = idx; host_wdata = val;
        @(posedge clk);
        @(negedge clk);
        host_sel = 1'b0; host_we = 1'b0; host_wdata = '0;
    endtask

    task automatic host_read(input logic [1:0] idx, output logic [31:0] val);
        host_addr = idx;
        #1;
        val = host_rdata;
    endtask

    task automatic init_mem();
        for (int i = 0; i < 256; i++) begin
            mem[i] = pat(8'(i));
            exp_mem[i] = pat(8'(i));
        end
    endtask

    // Expected memory from the operand-size and step rules (R3, R5).
    task automatic model_copy(input vec_t v);
        logic [23:0] sp, dp;
        logic [15:0] c;
        logic w;
        sp = v.src; dp = v.dst; c = v.cnt;
        while (c != 0) begin
            w = v.wide && !sp[0] && !dp[0] && (c >= 16'd2);
            exp_mem[dp[7:0]] = pat(sp[7:0]);
            if (w) exp_mem[dp[7:0] + 8'd1] = pat(sp[7:0] + 8'd1);
            if (v.src_inc) sp = sp + (w ? 24'd2 : 24'd1);
            if (v.dst_inc) dp = dp + (w ? 24'd2 : 24'd1);
            c = c - (w ? 16'd2 : 16'd1);
        end
    endtask

    task automatic check_mem(input string tag);
        int bad = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) bad++;
        check(tag, 32'(bad), 32'd0);
    endtask

    // Wait for done; returns the number of irq-high samples seen.
    task automatic wait_done(output int irq_hits);
        logic [31:0] r;
        irq_hits = 0;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (irq) irq_hits++;
            host_read(2'd0, r);
            if (r[8]) break;
        end
    endtask

    // Bus slave: grant follows request, ack after ack_lat wait clocks.
    initial begin
        int wcnt = 0;
        logic [7:0] a;
        forever begin
            @(negedge clk);
            bus_gnt = bus_req;
            if (bus_cyc && !bus_ack) begin
                if (wcnt >= ack_lat) begin
                    bus_ack = 1'b1;
                    wcnt = 0;
                    a = bus_addr[7:0];
                    if (!bus_wr) begin
                        bus_rdata = {mem[a + 8'd1], mem[a]};
                        if (rd_seen == 0) first_rd_addr = bus_addr;
                        rd_seen++;
                    end else begin
                        mem[a] = bus_wdata[7:0];
                        if (bus_size) mem[a + 8'd1] = bus_wdata[15:8];
                    end
                end else begin
                    wcnt++;
                end
            end else begin
                bus_ack = 1'b0;
                wcnt = 0;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [23:0] held_addr;
        int hits;
        init_mem();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < 4; i++) begin
            host_read(2'(i), r);
            check("R1 register reset", r, 32'h0);
        end
        check("R1 outputs idle", {29'h0, bus_req, bus_cyc, irq}, 32'h0);

        // R2: upper pointer bits read zero
        host_write(2'd1, 32'hFFABCDEF);
        host_read(2'd1, r);
        check("R2 source upper bits", r, 32'h00ABCDEF);
        host_write(2'd2, 32'h12FFFFFF);
        host_read(2'd2, r);
        check("R2 dest upper bits", r, 32'h00FFFFFF);

        // Vector table: operand size, step, wrap, fixed pointers, completion
        for (int n = 0; n < N_VEC; n++) begin
            init_mem();
            model_copy(VECS[n]);
            ack_lat = n % 3;
            host_write(2'd1, {8'h0, VECS[n].src});
            host_write(2'd2, {8'h0, VECS[n].dst});
            host_write(2'd3, {16'h0, VECS[n].cnt});
            host_write(2'd0, {26'h0, 1'b0, VECS[n].wide, VECS[n].dst_inc, VECS[n].src_inc, 2'b01});
            wait_done(hits);
            host_read(2'd1, r);
            check((n == 3) ? "R4 source end" : (n == 4) ? "R6 source end" : "R5 source end",
                  r, {8'h0, VECS[n].exp_src});
            host_read(2'd2, r);
            check((n == 7) ? "R4 dest end" : (n == 5) ? "R6 dest end" : "R5 dest end",
                  r, {8'h0, VECS[n].exp_dst});
            host_read(2'd3, r);
            check("R7 count zero", r, 32'h0);
            host_read(2'd0, r);
            check("R7 go clear done set", r & 32'h101, 32'h100);
            check("R7 irq seen once", 32'(hits), 32'd1);
            @(negedge clk);
            check("R7 irq one clock", {31'h0, irq}, 32'h0);
            check_mem("R3 copied data");
        end

        // R7: control write clears done
        host_write(2'd0, 32'h0000000C);
        host_read(2'd0, r);
        check("R7 done cleared by write", r & 32'h100, 32'h0);

        // R8: request one clock after go
        init_mem();
        ack_lat = 0;
        host_write(2'd1, 32'h10);
        host_write(2'd2, 32'h40);
        host_write(2'd3, 32'd2);
        host_write(2'd0, 32'h0000000D);
        check("R8 no request same clock", {31'h0, bus_req}, 32'h0);
        @(posedge clk); #1;
        check("R8 request next clock", {31'h0, bus_req}, 32'h1);
        wait_done(hits);
        host_read(2'd3, r);
        check("R8 transfer completes", r, 32'h0);

        // R10 and R12: stop during the first write cycle, then resume
        init_mem();
        model_copy('{24'h10, 24'h40, 16'd6, 1'b0, 1'b1, 1'b1, 24'h16, 24'h46});
        ack_lat = 3;
        rd_seen = 0;
        host_write(2'd1, 32'h10);
        host_write(2'd2, 32'h40);
        host_write(2'd3, 32'd6);
        host_write(2'd0, 32'h0000000D);
        for (int k = 0; k < 100; k++) begin
            if (bus_cyc && bus_wr) break;
            @(negedge clk);
        end
        held_addr = bus_addr;
        host_write(2'd0, 32'h0000000C);
        check("R12 write cycle held", {30'h0, bus_cyc, bus_wr}, 32'h3);
        check("R12 address held", {8'h0, bus_addr}, {8'h0, held_addr});
        check("R3 write address is dest", {8'h0, bus_addr}, 32'h40);
        check("R3 read address is source", {8'h0, first_rd_addr}, 32'h10);
        repeat (20) @(negedge clk);
        check("R10 parked", {31'h0, bus_req}, 32'h0);
        host_read(2'd3, r);
        check("R10 count kept", r, 32'd5);
        host_read(2'd1, r);
        check("R10 source kept", r, 32'h11);
        host_read(2'd2, r);
        check("R10 dest kept", r, 32'h41);
        host_read(2'd0, r);
        check("R10 not done", r & 32'h101, 32'h0);
        host_write(2'd0, 32'h0000000D);
        wait_done(hits);
        host_read(2'd1, r);
        check("R10 resumed source end", r, 32'h16);
        check_mem("R10 resumed data");

        // R9: external request mode
        init_mem();
        ack_lat = 0;
        host_write(2'd1, 32'h10);
        host_write(2'd2, 32'h40);
        host_write(2'd3, 32'd2);
        host_write(2'd0, 32'h0000002C);
        ext_dreq = 1'b1;
        hits = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (bus_req) hits++;
        end
        check("R9 request ignored while stopped", 32'(hits), 32'd0);
        ext_dreq = 1'b0;
        host_write(2'd0, 32'h0000002D);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (bus_req) hits++;
        end
        check("R9 no start without request", 32'(hits), 32'd0);
        ext_dreq = 1'b1;
        wait_done(hits);
        ext_dreq = 1'b0;
        host_read(2'd1, r);
        check("R9 transfer on request", r, 32'h12);

        // R11: reset bit aborts a read cycle
        ack_lat = 5;
        host_write(2'd1, 32'h10);
        host_write(2'd2, 32'h40);
        host_write(2'd3, 32'd4);
        host_write(2'd0, 32'h0000001D);
        for (int k = 0; k < 100; k++) begin
            if (bus_cyc && !bus_wr) break;
            @(negedge clk);
        end
        host_write(2'd0, 32'h00000002);
        check("R11 bus dropped", {30'h0, bus_req, bus_cyc}, 32'h0);
        host_read(2'd0, r);
        check("R11 control cleared", r, 32'h0);
        repeat (10) @(negedge clk);
        check("R11 stays idle", {30'h0, bus_req, bus_cyc}, 32'h0);
        host_read(2'd1, r);
        check("R11 source kept", r, 32'h10);
        host_read(2'd3, r);
        check("R11 count kept", r, 32'd4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule